// File: doc/BRIEF.md
# I2C Start/Stop Condition Issuer with Bus-Busy Monitor

This block is the condition-control slice of an I2C master. It holds an 8-bit control register whose top two bits form a command pair: a busy flag and a write-only issue-disable bit. Software writes the pair to ask for a start, a repeated start or a stop. A small sequencer then shapes the SCL and SDA lines through open-drain pull-low enables, with programmable hold and setup times counted in clock cycles.

The block also watches both lines. Each line passes through a synchronizer and an edge detector. The busy flag is set when SDA falls while SCL stays high, and cleared when SDA rises while SCL stays high. So the flag follows the real bus, whoever drives it, and not the write that asked for a condition. A mode input selects the clocked-synchronous serial format. In that format the busy flag reads as zero. Byte transfer, acknowledge and arbitration live in other blocks.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: After reset, `rd_data_o` reads 0x7D: busy flag (bit 7) is 0, disable bit (bit 6) is 1, and bits 5:0 read the fixed value 0x3D. Both pull enables are 0 and `seq_busy_o` is 0.
- R2: A falling SDA while SCL stays high sets bit 7 of `rd_data_o`. The flag is readable no later than 4 clock cycles after the line change.
- R3: A rising SDA while SCL stays high clears bit 7. The flag reads 0 no later than 4 cycles after the line change.
- R4: With `master_i`=1 and no sequence running, a write with bit 7=1 and bit 6=0 issues a start, in this order:
  - SCL is released and SDA is pulled low (`sda_pull_o`=1 while `scl_pull_o`=0);
  - SDA is held low for exactly HOLD_CNT cycles;
  - `scl_pull_o` then rises.
- R5: The same write while the bus is busy issues a repeated start. SDA is released first, then SCL, then SDA is pulled low again. The busy flag stays 1 throughout.
- R6: A write with bit 7=0 and bit 6=0 issues a stop, in this order:
  - both lines are pulled low;
  - `scl_pull_o` falls;
  - `sda_pull_o` falls exactly SETUP_CNT cycles later.
- R7: Bit 6 always reads 1. A write with bit 6=1 starts no sequence and changes no pull enable.
- R8: While `sync_mode_i`=1, bit 7 reads 0 even if the bus is busy. The flag shows again when the input returns to 0.
- R9: `seq_busy_o` is 1 while a sequence runs, starting the cycle after the command write. A command write made while `seq_busy_o`=1 is ignored, including a write on the sequence's final cycle.
- R10: A command write while `master_i`=0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 1 selects clocked-synchronous format (busy reads 0) |
| master_i | input | 1 | 1 when operating as bus master |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_o | output | 1 | Pull SCL low when 1 |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| seq_busy_o | output | 1 | Issue sequence in progress |

## Verification
A command write and the final cycle of a running sequence can meet on the same clock edge. In that cycle the sequencer leaves its timed state while the command decode sees a fresh request. The bench finds the point where SDA is pulled low in a start, counts HOLD_CNT-1 further cycles, and writes a stop command that lands on the exact edge where SCL is pulled. The result passes only if no stop follows: `seq_busy_o` stays low and both pull enables stay high. The bench closes the bus loop with pull-ups, so every issued condition is also judged through the busy flag that the monitor derives from it.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_RS_SDA,   // release SDA before raising SCL (repeated start)
    SEQ_RS_SCL,   // SCL released, setup before start edge
    SEQ_ST_HOLD,  // SDA low, SCL high: start hold
    SEQ_SP_LOW,   // both low before stop
    SEQ_SP_SCL    // SCL released, setup before stop edge
  } seq_state_e;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } line_sense_t;

  localparam logic [5:0] LOW_FIELD_VAL = 6'h3D;
endpackage

// File: rtl/i2c_line_sense.sv
module i2c_line_sense
  import i2c_cond_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        line_i,
  output line_sense_t sense_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  always_comb begin
    sense_o.lvl  = sync_q[STAGES-1];
    sense_o.rise = sync_q[STAGES-1] & ~prev_q;
    sense_o.fall = ~sync_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_cond_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  line_sense_t scl_i,
  input  line_sense_t sda_i,
  output logic        bus_busy_o
);
  logic scl_steady_hi, start_det, stop_det, busy_q;

  // SCL must have been high in the previous sample too
  assign scl_steady_hi = scl_i.lvl & ~scl_i.rise;
  assign start_det     = sda_i.fall & scl_steady_hi;
  assign stop_det      = sda_i.rise & scl_steady_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        busy_q <= 1'b0;
    else if (start_det) busy_q <= 1'b1;
    else if (stop_det)  busy_q <= 1'b0;
  end

  assign bus_busy_o = busy_q;
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
  import i2c_cond_pkg::*;
#(
  parameter int HOLD_CNT  = 4,
  parameter int SETUP_CNT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_req_i,
  input  logic stop_req_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic busy_o
);
  localparam int CNT_MAX = (HOLD_CNT > SETUP_CNT) ? HOLD_CNT : SETUP_CNT;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_CNT - 1);
  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CNT - 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          scl_q, sda_q;
  logic          cnt_done;

  assign cnt_done = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_req_i) begin
            sda_q   <= 1'b0;
            state_q <= SEQ_RS_SDA;
          end else if (stop_req_i) begin
            sda_q   <= 1'b1;
            scl_q   <= 1'b1;
            state_q <= SEQ_SP_LOW;
          end
        end
        SEQ_RS_SDA: begin
          scl_q   <= 1'b0;
          cnt_q   <= SETUP_LD;
          state_q <= SEQ_RS_SCL;
        end
        SEQ_RS_SCL: begin
          if (cnt_done) begin
            sda_q   <= 1'b1;
            cnt_q   <= HOLD_LD;
            state_q <= SEQ_ST_HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SEQ_ST_HOLD: begin
          if (cnt_done) begin
            scl_q   <= 1'b1;
            state_q <= SEQ_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SEQ_SP_LOW: begin
          scl_q   <= 1'b0;
          cnt_q   <= SETUP_LD;
          state_q <= SEQ_SP_SCL;
        end
        SEQ_SP_SCL: begin
          if (cnt_done) begin
            sda_q   <= 1'b0;
            state_q <= SEQ_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign scl_pull_o = scl_q;
  assign sda_pull_o = sda_q;
  assign busy_o     = (state_q != SEQ_IDLE);
endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cond_pkg::*;
#(
  parameter int HOLD_CNT    = 4,
  parameter int SETUP_CNT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_mode_i,
  input  logic       master_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_pull_o,
  output logic       sda_pull_o,
  output logic       seq_busy_o
);
  localparam int NLINES = 2;

  logic        line_raw [NLINES];
  line_sense_t sense    [NLINES];
  logic        bus_busy, cmd_ok, start_req, stop_req, seq_busy;

  assign line_raw[0] = scl_i;
  assign line_raw[1] = sda_i;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_sense #(.STAGES(SYNC_STAGES)) u_sense (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .line_i  (line_raw[g]),
      .sense_o (sense[g])
    );
  end

  i2c_cond_detect u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (sense[0]),
    .sda_i      (sense[1]),
    .bus_busy_o (bus_busy)
  );

  // bit6 = 0 marks a command; bit7 picks start (1) or stop (0)
  assign cmd_ok    = wr_en_i & master_i & ~wr_data_i[6];
  assign start_req = cmd_ok &  wr_data_i[7];
  assign stop_req  = cmd_ok & ~wr_data_i[7];

  i2c_cond_seq #(
    .HOLD_CNT  (HOLD_CNT),
    .SETUP_CNT (SETUP_CNT)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_req_i (start_req),
    .stop_req_i  (stop_req),
    .scl_pull_o  (scl_pull_o),
    .sda_pull_o  (sda_pull_o),
    .busy_o      (seq_busy)
  );

  assign seq_busy_o = seq_busy;
  assign rd_data_o  = {bus_busy & ~sync_mode_i, 1'b1, LOW_FIELD_VAL};
endmodule

// File: rtl/i2c_cond_chk.sv
module i2c_cond_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sync_mode_i,
  input logic       master_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       scl_i,
  input logic       sda_i,
  input logic       scl_pull_o,
  input logic       sda_pull_o,
  input logic       seq_busy_o
);
  assert_cmd_starts_seq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && master_i && !wr_data_i[6] && !seq_busy_o) |=> seq_busy_o);

  assert_disable_set_no_seq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[6] && !seq_busy_o) |=> !seq_busy_o);

  assert_slave_no_seq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !master_i && !seq_busy_o) |=> !seq_busy_o);

  assert_scl_low_with_sda_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_pull_o) |-> sda_pull_o);

  assert_stop_sda_after_scl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sda_pull_o) && !seq_busy_o) |-> (!scl_pull_o && $past(!scl_pull_o)));

  assert_sync_mode_busy_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_mode_i |-> !rd_data_o[7]);
endmodule

bind i2c_cond_ctrl i2c_cond_chk u_chk (.*);

// File: tb/tb_i2c_cond_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_cond_ctrl;
  localparam int HOLD  = 5;
  localparam int SETUP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_mode = 1'b0, master = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       scl_pull, sda_pull, seq_busy;
  logic       ext_scl_low = 1'b0, ext_sda_low = 1'b0;
  logic       scl_line, sda_line;

  int checks = 0, fails = 0;

  assign scl_line = ~(scl_pull | ext_scl_low);
  assign sda_line = ~(sda_pull | ext_sda_low);

  always #10 clk = ~clk;

  i2c_cond_ctrl #(.HOLD_CNT(HOLD), .SETUP_CNT(SETUP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(sync_mode), .master_i(master),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .scl_i(scl_line), .sda_i(sda_line), .scl_pull_o(scl_pull),
    .sda_pull_o(sda_pull), .seq_busy_o(seq_busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_R1;
    chk("R1 read value", rd_data, 8'h7D);
    chk("R1 pulls", {scl_pull, sda_pull}, 0);
    chk("R1 seq idle", seq_busy, 0);
  endtask

  task automatic t_line_cond_R2_R3_R8;
    ext_sda_low = 1'b1;
    wait_cyc(4);
    chk("R2 busy set by line start", rd_data[7], 1);
    sync_mode = 1'b1; wait_cyc(1);
    chk("R8 busy reads 0 in sync mode", rd_data[7], 0);
    sync_mode = 1'b0; wait_cyc(1);
    chk("R8 busy returns", rd_data[7], 1);
    ext_sda_low = 1'b0;
    wait_cyc(4);
    chk("R3 busy cleared by line stop", rd_data[7], 0);
  endtask

  task automatic t_disable_R7;
    wr(8'hC0);
    chk("R7 no seq for disable=1 start", seq_busy, 0);
    wr(8'h40);
    chk("R7 no seq for disable=1 stop", seq_busy, 0);
    wait_cyc(2);
    chk("R7 pulls unchanged", {scl_pull, sda_pull}, 0);
    chk("R7 bit6 reads 1", rd_data[6], 1);
  endtask

  task automatic t_slave_R10;
    master = 1'b0;
    wr(8'h80);
    wait_cyc(2);
    chk("R10 slave write ignored", {seq_busy, scl_pull, sda_pull}, 0);
    master = 1'b1;
  endtask

  task automatic t_start_R4;
    int n;
    wr(8'h80);
    chk("R9 seq busy after write", seq_busy, 1);
    n = 0;
    while (!sda_pull && n < 100) begin @(negedge clk); n++; end
    chk("R4 SCL released when SDA pulled", scl_pull, 0);
    n = 0;
    while (!scl_pull && n < 100) begin @(negedge clk); n++; end
    chk("R4 hold cycles", n, HOLD);
    wait_cyc(4);
    chk("R4 busy after own start", rd_data[7], 1);
    chk("R4 seq done", seq_busy, 0);
  endtask

  task automatic t_restart_R5;
    int n;
    int dropped;
    int rel_sda;
    dropped = 0; rel_sda = 0;
    wr(8'h80);
    n = 0;
    while (seq_busy && n < 100) begin
      if (!rd_data[7]) dropped = 1;
      if (!sda_pull && scl_pull) rel_sda = 1;
      @(negedge clk); n++;
    end
    wait_cyc(4);
    chk("R5 SDA released before SCL", rel_sda, 1);
    chk("R5 busy held", dropped, 0);
    chk("R5 busy after restart", rd_data[7], 1);
    chk("R5 final pulls", {scl_pull, sda_pull}, 2'b11);
  endtask

  task automatic t_stop_R6;
    int n;
    wr(8'h00);
    chk("R6 both low first", {scl_pull, sda_pull}, 2'b11);
    n = 0;
    while (scl_pull && n < 100) begin @(negedge clk); n++; end
    chk("R6 SDA still low at SCL release", sda_pull, 1);
    n = 0;
    while (sda_pull && n < 100) begin @(negedge clk); n++; end
    chk("R6 setup cycles", n, SETUP);
    wait_cyc(4);
    chk("R6 busy cleared by stop", rd_data[7], 0);
  endtask

  task automatic t_ignore_running_R9;
    int n;
    wr(8'h80);
    wr(8'h00);
    n = 0;
    while (seq_busy && n < 100) begin @(negedge clk); n++; end
    wait_cyc(3);
    chk("R9 stop during start ignored", {seq_busy, scl_pull, sda_pull}, 3'b011);
  endtask

  task automatic t_same_cycle_R9;
    int n;
    wr(8'h80);
    n = 0;
    while (sda_pull && n < 100) begin @(negedge clk); n++; end
    n = 0;
    while (!sda_pull && n < 100) begin @(negedge clk); n++; end
    repeat (HOLD - 1) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    chk("R9 seq ends on write edge", {seq_busy, scl_pull, sda_pull}, 3'b011);
    wait_cyc(3);
    chk("R9 final-cycle write ignored", {seq_busy, scl_pull, sda_pull}, 3'b011);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset_R1();
    t_line_cond_R2_R3_R8();
    t_disable_R7();
    t_slave_R10();
    t_start_R4();
    t_restart_R5();
    t_stop_R6();
    t_ignore_running_R9();
    t_same_cycle_R9();
    t_stop_R6();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule